// File: doc/BRIEF.md
# Serial Flash Interface Pause Controller

This block holds the pause logic for the slave side of a serial flash interface. It runs on a fast system clock, well above the serial clock rate. It passes the chip-select, serial clock and pause pins through synchronizers, then works only on the synchronized copies. From those copies it finds the serial clock edges and issues them as one-cycle strobes to the command engine. A rising edge means "sample input". A falling edge means "shift the next output bit".

The pause pin can freeze a transfer that is under way. The pause state is entered and left only while the serial clock is low. If the pause pin changes while the clock is high, the change waits until the clock next goes low. While paused, no strobes go out, the bit position stays where it is and the data-output enable is forced off. If chip select goes inactive during a pause, the block clears the pause and sends a one-cycle reset request to the rest of the interface. A transfer that was paused carries on at the same bit position once the pause pin is released.

Top module: `spi_hold_ctrl`

## Requirements
- R1: While rst_n is low and in the first cycle after it, paused, sample_stb, shift_stb, dout_oe and iface_rst are 0 and bit_pos is 0.
- R2: The pause is entered only when all three synchronized inputs are low: chip select (active low), the pause pin (active low) and the serial clock. paused goes to 1 three clock cycles after the last of these pin changes: two synchronizer stages plus the state register. With chip select high, the pause pin has no effect.
- R3: If the pause pin falls while the serial clock is high, paused stays 0 until the synchronized clock is low. If the pin rises again before that, no pause occurs.
- R4: If the pause pin rises while the serial clock is low, paused clears with the same three-cycle latency. If it rises while the clock is high, paused stays 1 until the synchronized clock is low.
- R5: While the pause pin stays low and chip select stays low, paused stays 1 whatever the serial clock does.
- R6: sample_stb pulses for one cycle on each synchronized rising clock edge. shift_stb pulses for one cycle on each synchronized falling clock edge. Both need chip select low and no pause. shift_stb also needs the synchronized pause pin high. Neither pulses while paused.
- R7: bit_pos is a modulo 2^BIT_W count of sample_stb pulses. It is cleared whenever synchronized chip select is high, and it does not change while paused.
- R8: dout_oe equals dout_req AND (synchronized chip select low) AND (not paused).
- R9: If synchronized chip select is high while paused, paused clears on the next cycle and iface_rst is 1 for exactly that one cycle. bit_pos is cleared at the same time.
- R10: If chip select returns low while the pause pin is still low, the pause is entered again as soon as the synchronized clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low, asynchronous |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| hold_n_pin | input | 1 | Pause pin, active low, asynchronous |
| dout_req | input | 1 | Command engine wants to drive the data output |
| paused | output | 1 | Interface is in the pause state |
| sample_stb | output | 1 | Rising serial clock edge strobe |
| shift_stb | output | 1 | Falling serial clock edge strobe |
| dout_oe | output | 1 | Data-output enable for the pad buffer |
| iface_rst | output | 1 | One-cycle interface reset request |
| bit_pos | output | BIT_W | Bit position within the current byte |

## Verification
The pause pin is driven in four ways against the serial clock. It falls and rises while the clock is low, which shows immediate entry and exit. It falls and rises while the clock is high, which shows that entry and exit are deferred. It falls while the clock is high and returns before the clock drops, which shows that a short pulse is dropped. It falls while chip select is high, which shows the chip-select qualification. Serial clock pulses given during a pause show whether bit_pos is truly frozen, as against strobes only being masked. A chip-select release inside a pause, and re-selection with the pause pin still low, separate the reset request from the re-entry path. Transfers longer than one byte exercise bit_pos wrap-around, and dout_req toggling separates the output-enable gating from the pause state.

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int BIT_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_pin,
  input  logic             sck_pin,
  input  logic             hold_n_pin,
  input  logic             dout_req,
  output logic             paused,
  output logic             sample_stb,
  output logic             shift_stb,
  output logic             dout_oe,
  output logic             iface_rst,
  output logic [BIT_W-1:0] bit_pos
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] cs_sr, sck_sr, hold_sr;
  logic cs_s, sck_s, hold_s, sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr   <= '1;
      sck_sr  <= '0;
      hold_sr <= '1;
      sck_d   <= 1'b0;
    end else begin
      cs_sr   <= {cs_sr[TOP-1:0], cs_n_pin};
      sck_sr  <= {sck_sr[TOP-1:0], sck_pin};
      hold_sr <= {hold_sr[TOP-1:0], hold_n_pin};
      sck_d   <= sck_s;
    end
  end

  assign cs_s   = cs_sr[TOP];
  assign sck_s  = sck_sr[TOP];
  assign hold_s = hold_sr[TOP];

  logic active;
  assign active     = !cs_s && !paused;
  assign sample_stb = active && sck_s && !sck_d;
  assign shift_stb  = active && !sck_s && sck_d && hold_s;
  assign dout_oe    = active && dout_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused    <= 1'b0;
      iface_rst <= 1'b0;
      bit_pos   <= '0;
    end else begin
      iface_rst <= cs_s && paused;
      if (cs_s)
        paused <= 1'b0;
      else if (!sck_s)
        paused <= !hold_s;
      if (cs_s)
        bit_pos <= '0;
      else if (sample_stb)
        bit_pos <= bit_pos + 1'b1;
    end
  end

endmodule

// File: rtl/spi_hold_ctrl_chk.sv
module spi_hold_ctrl_chk #(
  parameter int BIT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_s,
  input logic             sck_s,
  input logic             hold_s,
  input logic             paused,
  input logic             sample_stb,
  input logic             shift_stb,
  input logic             dout_oe,
  input logic             iface_rst,
  input logic [BIT_W-1:0] bit_pos
);

  AST_NO_STROBE_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !sample_stb && !shift_stb); // R6

  AST_OE_OFF_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !dout_oe); // R8

  AST_ENTER_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> $past(!sck_s) && $past(!hold_s) && $past(!cs_s)); // R2

  AST_EXIT_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused) |-> $past(cs_s) || ($past(!sck_s) && $past(hold_s))); // R4

  AST_POS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !cs_s) |=> $stable(bit_pos)); // R7

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    iface_rst |-> $past(paused) && $past(cs_s) && !paused); // R9

endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk #(.BIT_W(BIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .hold_s(hold_s),
  .paused(paused), .sample_stb(sample_stb), .shift_stb(shift_stb),
  .dout_oe(dout_oe), .iface_rst(iface_rst), .bit_pos(bit_pos)
);

// File: tb/spi_hold_ctrl_tb.sv
module spi_hold_ctrl_tb;
  localparam int SYNC = 2;
  localparam int BW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, dreq = 1'b0;
  logic paused, sample_stb, shift_stb, dout_oe, iface_rst;
  logic [BW-1:0] bit_pos;

  always #4 clk = ~clk;

  spi_hold_ctrl #(.SYNC_STAGES(SYNC), .BIT_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck), .hold_n_pin(hold_n),
    .dout_req(dreq), .paused(paused), .sample_stb(sample_stb), .shift_stb(shift_stb),
    .dout_oe(dout_oe), .iface_rst(iface_rst), .bit_pos(bit_pos)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: pin history as queues, front entry is the synchronized view
  bit q_cs[$], q_sck[$], q_hold[$];
  bit m_sckd, m_paused, m_rst;
  int m_pos;

  function automatic bit m_sample();
    return q_sck[0] && !m_sckd && !q_cs[0] && !m_paused;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q_cs = {}; q_sck = {}; q_hold = {};
      for (int i = 0; i < SYNC; i++) begin
        q_cs.push_back(1'b1); q_sck.push_back(1'b0); q_hold.push_back(1'b1);
      end
      m_sckd = 0; m_paused = 0; m_rst = 0; m_pos = 0;
    end else begin
      bit c, s, h, nxt;
      c = q_cs[0]; s = q_sck[0]; h = q_hold[0];
      if (c) m_pos = 0;
      else if (m_sample()) m_pos = (m_pos + 1) % (1 << BW);
      m_rst = c && m_paused;
      nxt = m_paused;
      if (c) nxt = 0;
      else if (!m_paused && !h && !s) nxt = 1;
      else if (m_paused && h && !s) nxt = 0;
      m_paused = nxt;
      m_sckd = s;
      void'(q_cs.pop_front()); void'(q_sck.pop_front()); void'(q_hold.pop_front());
      q_cs.push_back(cs_n); q_sck.push_back(sck); q_hold.push_back(hold_n);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit shf;
      shf = !q_sck[0] && m_sckd && !q_cs[0] && !m_paused && q_hold[0];
      chk("R2 R3 R4 R5 R10 paused", paused, m_paused);
      chk("R6 sample_stb", sample_stb, m_sample());
      chk("R6 shift_stb", shift_stb, shf);
      chk("R8 dout_oe", dout_oe, dreq && !q_cs[0] && !m_paused);
      chk("R9 iface_rst", iface_rst, m_rst);
      chk("R7 bit_pos", bit_pos, m_pos);
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(bit c, bit s, bit h);
    @(negedge clk); #1;
    cs_n = c; sck = s; hold_n = h;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1 sck = 1'b1;
      wait_n(3);
      #1 sck = 1'b0;
      wait_n(3);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int saved;
    wait_n(3);
    // R1 reset state
    chk("R1 paused", paused, 0); chk("R1 sample_stb", sample_stb, 0);
    chk("R1 shift_stb", shift_stb, 0); chk("R1 dout_oe", dout_oe, 0);
    chk("R1 iface_rst", iface_rst, 0); chk("R1 bit_pos", bit_pos, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 paused after reset", paused, 0);
    chk("R1 bit_pos after reset", bit_pos, 0);

    // R2: pause pin low with chip select high has no effect
    drive(1, 0, 0); wait_n(6);
    chk("R2 no pause while deselected", paused, 0);
    drive(1, 0, 1); wait_n(4);

    // Normal transfer with wrap, output requested
    drive(0, 0, 1); #1 dreq = 1'b1;
    pulses(10);
    chk("R7 wrap after 10 bits", bit_pos, 10 % 8);
    #1 dreq = 1'b0;
    pulses(1);

    // R2 / R5 / R4: entry and exit while clock low, clock toggles in between
    drive(0, 0, 0); #1 dreq = 1'b1;
    wait_n(2);
    chk("R2 not yet paused (sync latency)", paused, 0);
    wait_n(3);
    chk("R2 paused after clock-low fall", paused, 1);
    chk("R8 oe off while paused", dout_oe, 0);
    saved = bit_pos;
    pulses(3);
    chk("R5 still paused", paused, 1);
    chk("R7 bit_pos frozen", bit_pos, saved);
    drive(0, 0, 1); wait_n(5);
    chk("R4 exit while clock low", paused, 0);
    pulses(2);
    chk("R7 resumes from frozen position", bit_pos, (saved + 2) % 8);

    // R3 / R4: edges while clock high are deferred
    drive(0, 1, 1); wait_n(4);
    drive(0, 1, 0); wait_n(6);
    chk("R3 deferred while clock high", paused, 0);
    drive(0, 0, 0); wait_n(5);
    chk("R3 entered once clock low", paused, 1);
    drive(0, 1, 0); wait_n(3);
    drive(0, 1, 1); wait_n(6);
    chk("R4 exit deferred while clock high", paused, 1);
    drive(0, 0, 1); wait_n(5);
    chk("R4 exit once clock low", paused, 0);

    // R3: short pause pulse during clock high is dropped
    drive(0, 1, 1); wait_n(4);
    drive(0, 1, 0); wait_n(3);
    drive(0, 1, 1); wait_n(4);
    drive(0, 0, 1); wait_n(5);
    chk("R3 dropped pulse", paused, 0);
    pulses(3);

    // R9 / R10: deselect during pause, reselect with pause pin still low
    drive(0, 0, 0); wait_n(5);
    chk("R9 paused before deselect", paused, 1);
    drive(1, 0, 0); wait_n(5);
    chk("R9 pause cleared by deselect", paused, 0);
    chk("R9 bit_pos cleared", bit_pos, 0);
    drive(0, 1, 0); wait_n(5);
    chk("R10 waits for clock low", paused, 0);
    drive(0, 0, 0); wait_n(5);
    chk("R10 re-entered", paused, 1);
    drive(0, 0, 1); #1 dreq = 1'b0;
    pulses(4);
    drive(1, 0, 1); wait_n(6);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule